// File: doc/BRIEF.md
# UART Loopback and Modem Status Unit

This unit sits between the register front end of a UART and its receive buffer. It holds the control word (loopback enable plus four modem control outputs) and the four modem status flags, and it decides which characters are handed to the receive buffer. Each hand-off is a one-cycle push request carrying a receive word: the data byte in the low bits and a break marker in the top bit.

When loopback is enabled, every control write copies the modem control outputs onto the status flags. The same write rebuilds the modem-status interrupt bits from the new flags. Bytes written for transmission, and a newly raised send-break, are handed straight back to the receive buffer. Characters and break events from the external receive line are dropped. When loopback is off, the flags keep their values. External characters are passed through, and so are external break events when the receive FIFO is disabled; such a break also raises a break-error flag. Serial bit timing is not modelled.

All outputs are registered and reflect an input one clock edge after it is presented.

Top module: `uart_loop_modem`

## Requirements
- R1: After reset, loop_en, ms_flags, ms_irq, push_vld and brk_err are all 0, and the stored send-break state is 0.
- R2: Control word bits are: bit0 loopback enable, bit1 DTR, bit2 RTS, bit3 OUT1, bit4 OUT2. Flag and interrupt vectors are: bit0 CTS, bit1 DSR, bit2 DCD, bit3 RI. A control write with bit0 = 1 sets, at the next edge, CTS = RTS, DSR = DTR, DCD = OUT1 and RI = OUT2. This includes the write that first turns loopback on. loop_en follows bit0 of every control write.
- R3: On such a mapping write, ms_irq becomes exactly the new flag vector, dropping all older bits. Otherwise, each 1 in irq_clr clears that ms_irq bit at the next edge. A mapping write wins over a clear in the same cycle.
- R4: While loop_en = 1, tx_wr yields, one cycle later, a push whose word is {3'b000, tx_data}.
- R5: While loop_en = 1, rx_valid and ext_brk cause no push and leave brk_err unchanged.
- R6: brk_wr stores brk_val as the send-break state. If brk_val = 1, the stored state was 0 and loop_en = 1, a push of the break word (only bit 10 set) follows one cycle later, and it takes precedence over a tx_wr in the same cycle. Rewriting the same value pushes nothing.
- R7: With loop_en = 0 and fifo_en = 0, ext_brk pushes the break word and sets brk_err; it takes precedence over rx_valid in the same cycle. With fifo_en = 1, ext_brk has no effect. err_clr clears brk_err, but a break in the same cycle wins.
- R8: While loop_en = 0, control writes leave ms_flags unchanged, tx_wr pushes nothing, and rx_valid pushes {3'b000, rx_data}.
- R9: push_vld is high for exactly one cycle per accepted event and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word (R2 layout) |
| irq_clr | input | 4 | Write-one-to-clear for modem interrupt bits |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| brk_wr | input | 1 | Line control write carrying the send-break bit |
| brk_val | input | 1 | New send-break value |
| fifo_en | input | 1 | Receive FIFO mode enabled |
| rx_valid | input | 1 | External received character strobe |
| rx_data | input | 8 | External received character |
| ext_brk | input | 1 | External break event |
| err_clr | input | 1 | Clear of the break-error flag |
| loop_en | output | 1 | Loopback enable state |
| ms_flags | output | 4 | Modem status flags CTS, DSR, DCD, RI |
| ms_irq | output | 4 | Modem-status interrupt bits |
| push_vld | output | 1 | Receive buffer push request |
| push_word | output | 11 | Receive word: data in 7:0, break marker in bit 10 |
| brk_err | output | 1 | Break-error flag |

## Verification
A crossed control-to-flag pair shows on ms_flags at the edge after the first loopback write. A stale or missing interrupt rebuild shows on ms_irq at that same edge. A wrong loopback state shows within one cycle: external bytes leak onto push_vld, or transmitted bytes fail to appear. A lost send-break history shows as a missing or duplicated break word on the next break write. Random streams mixing all strobes are compared edge by edge against a bench model, so every divergence is caught at the cycle it first appears.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int CW      = 5;
  localparam int CTL_LB  = 0;
  localparam int CTL_DTR = 1;
  localparam int CTL_RTS = 2;
  localparam int CTL_O1  = 3;
  localparam int CTL_O2  = 4;

  localparam int MS_N   = 4;
  localparam int MS_CTS = 0;
  localparam int MS_DSR = 1;
  localparam int MS_DCD = 2;
  localparam int MS_RI  = 3;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_LBRK, SRC_TX, SRC_XBRK, SRC_RX
  } push_src_e;

  function automatic logic [MS_N-1:0] ctrl_to_ms(input logic [CW-1:0] c);
    logic [MS_N-1:0] r;
    r         = '0;
    r[MS_CTS] = c[CTL_RTS];
    r[MS_DSR] = c[CTL_DTR];
    r[MS_DCD] = c[CTL_O1];
    r[MS_RI]  = c[CTL_O2];
    return r;
  endfunction
endpackage

// File: rtl/lb_modem_map.sv
module lb_modem_map
  import uart_lb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [CW-1:0]   ctrl_wdata,
  input  logic [MS_N-1:0] irq_clr,
  output logic            loop_en,
  output logic [MS_N-1:0] ms_flags,
  output logic [MS_N-1:0] ms_irq,
  output logic            map_evt
);
  logic [MS_N-1:0] new_flags;

  assign map_evt   = ctrl_wr & ctrl_wdata[CTL_LB];
  assign new_flags = ctrl_to_ms(ctrl_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_en  <= 1'b0;
      ms_flags <= '0;
      ms_irq   <= '0;
    end else begin
      if (ctrl_wr) loop_en <= ctrl_wdata[CTL_LB];
      if (map_evt) begin
        ms_flags <= new_flags;
        ms_irq   <= new_flags;
      end else begin
        ms_irq <= ms_irq & ~irq_clr;
      end
    end
  end

  p_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    map_evt |=> (ms_flags[MS_CTS] == $past(ctrl_wdata[CTL_RTS])) &&
                (ms_flags[MS_RI]  == $past(ctrl_wdata[CTL_O2])));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_evt |=> $stable(ms_flags));
  p_rebuild_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_evt |=> ms_irq == ms_flags);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !map_evt |=> (ms_irq & $past(irq_clr)) == '0);
endmodule

// File: rtl/lb_break_track.sv
module lb_break_track (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_wr,
  input  logic brk_val,
  input  logic loop_en,
  input  logic fifo_en,
  input  logic ext_brk,
  input  logic err_clr,
  output logic loop_brk_evt,
  output logic ext_brk_evt,
  output logic brk_err
);
  logic brk_q;

  assign loop_brk_evt = brk_wr & brk_val & ~brk_q & loop_en;
  assign ext_brk_evt  = ext_brk & ~loop_en & ~fifo_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q   <= 1'b0;
      brk_err <= 1'b0;
    end else begin
      if (brk_wr) brk_q <= brk_val;
      if (ext_brk_evt)  brk_err <= 1'b1;
      else if (err_clr) brk_err <= 1'b0;
    end
  end

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_brk_evt |=> brk_err);
  p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en && !err_clr |=> brk_err == $past(brk_err));
endmodule

// File: rtl/lb_push_arb.sv
module lb_push_arb
  import uart_lb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              loop_brk_evt,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ext_brk_evt,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              push_vld,
  output logic [DATA_W+2:0] push_word
);
  localparam int WORD_W  = DATA_W + 3;
  localparam int BRK_BIT = DATA_W + 2;
  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << BRK_BIT;

  push_src_e src;

  function automatic logic [WORD_W-1:0] data_word(input logic [DATA_W-1:0] d);
    return {3'b000, d};
  endfunction

  always_comb begin
    if (loop_brk_evt)            src = SRC_LBRK;
    else if (loop_en && tx_wr)   src = SRC_TX;
    else if (ext_brk_evt)        src = SRC_XBRK;
    else if (!loop_en && rx_valid) src = SRC_RX;
    else                         src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_vld  <= 1'b0;
      push_word <= '0;
    end else begin
      push_vld <= (src != SRC_NONE);
      case (src)
        SRC_LBRK, SRC_XBRK: push_word <= BRK_WORD;
        SRC_TX:             push_word <= data_word(tx_data);
        SRC_RX:             push_word <= data_word(rx_data);
        default:            push_word <= push_word;
      endcase
    end
  end

  p_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en && tx_wr && !loop_brk_evt |=>
      push_vld && push_word == {3'b000, $past(tx_data)});
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en && !tx_wr && !loop_brk_evt |=> !push_vld);
  p_brk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_brk_evt |=> push_vld && push_word == BRK_WORD);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_brk_evt && !tx_wr && !ext_brk_evt && !rx_valid |=> !push_vld);
endmodule

// File: rtl/uart_loop_modem.sv
module uart_loop_modem
  import uart_lb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [4:0]        ctrl_wdata,
  input  logic [3:0]        irq_clr,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              brk_wr,
  input  logic              brk_val,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              ext_brk,
  input  logic              err_clr,
  output logic              loop_en,
  output logic [3:0]        ms_flags,
  output logic [3:0]        ms_irq,
  output logic              push_vld,
  output logic [DATA_W+2:0] push_word,
  output logic              brk_err
);
  logic map_evt;
  logic loop_brk_evt;
  logic ext_brk_evt;

  lb_modem_map u_map (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .irq_clr(irq_clr), .loop_en(loop_en), .ms_flags(ms_flags),
    .ms_irq(ms_irq), .map_evt(map_evt)
  );

  lb_break_track u_brk (
    .clk(clk), .rst_n(rst_n), .brk_wr(brk_wr), .brk_val(brk_val),
    .loop_en(loop_en), .fifo_en(fifo_en), .ext_brk(ext_brk),
    .err_clr(err_clr), .loop_brk_evt(loop_brk_evt),
    .ext_brk_evt(ext_brk_evt), .brk_err(brk_err)
  );

  lb_push_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .loop_brk_evt(loop_brk_evt), .tx_wr(tx_wr), .tx_data(tx_data),
    .ext_brk_evt(ext_brk_evt), .rx_valid(rx_valid), .rx_data(rx_data),
    .push_vld(push_vld), .push_word(push_word)
  );

  p_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> loop_en == $past(ctrl_wdata[CTL_LB]));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_vld && !tx_wr && !rx_valid && !brk_wr && !ext_brk |=> !push_vld);
endmodule

// File: tb/test_uart_loop_modem.sv
`timescale 1ns/1ps
module test_uart_loop_modem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 0; logic [4:0] ctrl_wdata = 0; logic [3:0] irq_clr = 0;
  logic tx_wr = 0; logic [7:0] tx_data = 0;
  logic brk_wr = 0; logic brk_val = 0; logic fifo_en = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0; logic ext_brk = 0; logic err_clr = 0;
  logic loop_en; logic [3:0] ms_flags; logic [3:0] ms_irq;
  logic push_vld; logic [10:0] push_word; logic brk_err;

  always #4 clk = ~clk;

  uart_loop_modem i_uart_loop_modem (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .irq_clr(irq_clr), .tx_wr(tx_wr), .tx_data(tx_data), .brk_wr(brk_wr),
    .brk_val(brk_val), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .ext_brk(ext_brk), .err_clr(err_clr),
    .loop_en(loop_en), .ms_flags(ms_flags), .ms_irq(ms_irq),
    .push_vld(push_vld), .push_word(push_word), .brk_err(brk_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic e_loop = 0, e_vld = 0, e_err = 0, e_brk = 0;
  logic [3:0] e_flags = 0, e_irq = 0;
  logic [10:0] e_word = 0;
  string push_tag = "R1";

  // RI, DCD, DSR, CTS taken from OUT2, OUT1, DTR, RTS
  function automatic logic [3:0] want_flags(input logic [4:0] w);
    return {w[4], w[3], w[1], w[2]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 loop_en", loop_en, e_loop);
    chk("R2 ms_flags", ms_flags, e_flags);
    chk("R3 ms_irq", ms_irq, e_irq);
    chk({push_tag, " push_vld"}, push_vld, e_vld);
    if (e_vld) chk({push_tag, " push_word"}, push_word, e_word);
    chk("R7 brk_err", brk_err, e_err);
  endtask

  task automatic model();
    logic lb_brk, x_brk;
    lb_brk = brk_wr && brk_val && !e_brk && e_loop;
    x_brk  = ext_brk && !e_loop && !fifo_en;
    e_vld = 1'b1;
    if (lb_brk)                   begin e_word = 11'h400; push_tag = "R6"; end
    else if (e_loop && tx_wr)     begin e_word = {3'b0, tx_data}; push_tag = "R4"; end
    else if (x_brk)               begin e_word = 11'h400; push_tag = "R7"; end
    else if (!e_loop && rx_valid) begin e_word = {3'b0, rx_data}; push_tag = "R8"; end
    else begin e_vld = 1'b0; push_tag = e_loop ? "R5" : "R9"; end
    if (x_brk) e_err = 1'b1; else if (err_clr) e_err = 1'b0;
    if (ctrl_wr && ctrl_wdata[0]) begin
      e_flags = want_flags(ctrl_wdata);
      e_irq   = e_flags;
    end else e_irq = e_irq & ~irq_clr;
    if (ctrl_wr) e_loop = ctrl_wdata[0];
    if (brk_wr) e_brk = brk_val;
  endtask

  task automatic idle();
    ctrl_wr = 0; irq_clr = 0; tx_wr = 0; brk_wr = 0;
    rx_valid = 0; ext_brk = 0; err_clr = 0;
  endtask

  task automatic tick();
    model();
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    push_tag = "R1";
    chk("R1 reset loop_en", loop_en, 0);
    chk("R1 reset flags", ms_flags, 0);
    chk("R1 reset irq", ms_irq, 0);
    chk("R1 reset push", push_vld, 0);
    chk("R1 reset brk_err", brk_err, 0);

    // R8: loop off, ctrl write keeps flags, tx pushes nothing, rx passes
    ctrl_wr = 1; ctrl_wdata = 5'b11110; tick();
    tx_wr = 1; tx_data = 8'h5a; tick();
    rx_valid = 1; rx_data = 8'hc3; tick();
    // R2: the enabling write maps at once (RTS=1, OUT2=1)
    ctrl_wr = 1; ctrl_wdata = 5'b10101; tick();
    // R3: clear one bit, then mapping write beats clear
    irq_clr = 4'b0001; tick();
    ctrl_wr = 1; ctrl_wdata = 5'b01011; irq_clr = 4'b1111; tick();
    // R4 and R5
    tx_wr = 1; tx_data = 8'ha7; tick();
    rx_valid = 1; rx_data = 8'h11; ext_brk = 1; tick();
    // R6: break beats tx, repeat value pushes nothing, then drop break
    brk_wr = 1; brk_val = 1; tx_wr = 1; tx_data = 8'h33; tick();
    brk_wr = 1; brk_val = 1; tick();
    brk_wr = 1; brk_val = 0; tick();
    // R7: loop off, fifo off external break beats rx char
    ctrl_wr = 1; ctrl_wdata = 5'b00000; tick();
    fifo_en = 0; ext_brk = 1; rx_valid = 1; rx_data = 8'h44; tick();
    err_clr = 1; ext_brk = 1; tick();
    err_clr = 1; tick();
    fifo_en = 1; ext_brk = 1; tick();
    fifo_en = 0;

    for (int i = 0; i < 4000; i++) begin
      ctrl_wr    = ($urandom % 8) == 0;
      ctrl_wdata = 5'($urandom);
      irq_clr    = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
      tx_wr      = ($urandom % 4) == 0;
      tx_data    = 8'($urandom);
      brk_wr     = ($urandom % 6) == 0;
      brk_val    = 1'($urandom);
      fifo_en    = ($urandom % 3) == 0;
      rx_valid   = ($urandom % 3) == 0;
      rx_data    = 8'($urandom);
      ext_brk    = ($urandom % 8) == 0;
      err_clr    = ($urandom % 6) == 0;
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule